// File: doc/BRIEF.md
# DRAM Controller Performance Counter Unit

This block watches a DRAM controller and counts what it does. It has four counters behind a small 32-bit register port. Counter 0 always counts clock cycles. Counters 1, 2 and 3 each count one event that software picks with an 8-bit select code. Most codes pick a single-cycle strobe from the controller's event vector. Two codes instead count read or write requests whose AXI ID passes a shared ID/mask filter. For those two codes the unit also adds up the bytes moved, and software can read that total next to the burst count.

The cycle counter controls all the others. While it is disabled or has overflowed, every counter holds its value and incoming events are dropped. Its overflow is the only source of the interrupt. Counters 1 to 3 wrap to zero without raising a flag. Software uses the cycle-counter interrupt as its cue to sample every counter, and then restarts the cycle counter.

Top module: `dram_perf_monitor`

## Requirements
- R1: After reset, every count, byte total and the filter register read 0. Each control register reads 0x00000002 (CLEAR=1, ENABLE=0, overflow=0), and `irq` is low. Control register n sits at byte address 4*n, count n at 0x20+4*n, the filter at 0x30, and byte total n at 0x30+4*n for n=1..3.
- R2: Control bit 2 is ENABLE. While counter 0 is enabled and its overflow flag (bit 0) is clear, it adds one on every clock edge. Its select field (bits 31:24) always reads 0, and writes to that field are ignored.
- R3: Writing control bit 1 (CLEAR) of counter 0 as 0 does not change the count. A following write with CLEAR=1 zeroes the count on that edge. A CLEAR=1 write when CLEAR already reads 1 leaves the count unchanged.
- R4: Writing CLEAR=0 to counter 1..3 zeroes its count and byte total on that edge. The CLEAR bit reads 0 for one cycle and reads 1 again from the next edge on.
- R5: With select code c below NUM_EVT (and not 0x41 or 0x42), an enabled counter 1..3 adds one on each edge where `evt_strobe[c]` is high. A code of NUM_EVT or above, other than 0x41 and 0x42, counts nothing.
- R6: Code 0x41 counts read requests and code 0x42 counts write requests, one per valid cycle, when ((id XOR filter[15:0]) AND NOT filter[31:16]) is zero. A 1 in filter[31:16] marks an ID bit as ignored.
- R7: For a counter on code 0x41 or 0x42, the byte total adds (len+1) * 2^size for each counted request, modulo 2^32.
- R8: When counter 0 steps from all ones to zero, its overflow flag sets and `irq` rises on the same edge. All four counters then hold their values and drop events.
- R9: Counters 1..3 wrap from all ones to zero and keep counting. Their overflow bit always reads 0, and their wrap never raises `irq`.
- R10: Writing ENABLE=0 to counter 0 freezes all four counters. Writing ENABLE=1 again, with CLEAR=1, resumes counting from the held values.
- R11: `irq` stays high until a write to counter 0's control register has bit 0 equal to 0. A write with bit 0 equal to 1 leaves `irq` and the freeze in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wen | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_strobe | input | NUM_EVT | Controller event pulses, one bit per select code |
| rd_req_vld | input | 1 | A read request is presented this cycle |
| rd_req_id | input | 16 | Read request AXI ID |
| rd_req_len | input | 8 | Read beats minus one |
| rd_req_size | input | 3 | Read bytes per beat as a power of two |
| wr_req_vld | input | 1 | A write request is presented this cycle |
| wr_req_id | input | 16 | Write request AXI ID |
| wr_req_len | input | 8 | Write beats minus one |
| wr_req_size | input | 3 | Write bytes per beat as a power of two |
| irq | output | 1 | Cycle-counter overflow interrupt |

## Verification
Inputs change on the falling edge. Register writes, strobes and requests are therefore captured on the next rising edge, and their effect can be read at the falling edge that follows. Reads are combinational from the registers, so a result is checked one edge after its stimulus. Counter 0 advances once per edge from the edge that clears it. The bench counts falling edges from that point to get exact values, including the wrap on the 2^CYC_W-th edge. The CLEAR self-restore shows one edge after the write, and the bench checks the bit on both sides of that edge.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    localparam int NUM_CTR  = 4;
    localparam int ID_W     = 16;
    localparam int LEN_W    = 8;
    localparam int SIZE_W   = 3;
    localparam int BYTE_W   = 32;

    localparam logic [7:0] CODE_AXID_RD = 8'h41;
    localparam logic [7:0] CODE_AXID_WR = 8'h42;

    localparam logic [5:0] WORD_CNT_BASE  = 6'h08;
    localparam logic [5:0] WORD_FILT      = 6'h0C;

    localparam int BIT_OVF = 0;
    localparam int BIT_CLR = 1;
    localparam int BIT_EN  = 2;
endpackage

// File: rtl/dpm_axid_match.sv
module dpm_axid_match
    import dpm_pkg::*;
(
    input  logic              req_vld,
    input  logic [ID_W-1:0]   req_id,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [ID_W-1:0]   filt_id,
    input  logic [ID_W-1:0]   filt_ign,
    output logic              hit,
    output logic [BYTE_W-1:0] bytes
);
    logic [LEN_W:0] beats;

    always_comb begin
        beats = {1'b0, req_len} + 1'b1;
        hit   = req_vld && (((req_id ^ filt_id) & ~filt_ign) == '0);
        bytes = BYTE_W'(beats) << req_size;
    end
endmodule

// File: rtl/dpm_event_slice.sv
module dpm_event_slice
    import dpm_pkg::*;
#(
    parameter int EVC_W   = 32,
    parameter int NUM_EVT = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               ctl_we,
    input  logic [7:0]         ctl_sel,
    input  logic               ctl_en,
    input  logic               ctl_clr,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic               rd_hit,
    input  logic [BYTE_W-1:0]  rd_bytes,
    input  logic               wr_hit,
    input  logic [BYTE_W-1:0]  wr_bytes,
    output logic [7:0]         sel_o,
    output logic               en_o,
    output logic               clr_o,
    output logic [EVC_W-1:0]   cnt_o,
    output logic [BYTE_W-1:0]  bytes_o
);
    typedef struct packed {
        logic              en;
        logic              clr;
        logic [7:0]        sel;
        logic [EVC_W-1:0]  cnt;
        logic [BYTE_W-1:0] bcnt;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic [NUM_EVT-1:0] strobe_sh;
    logic               ev_hit;
    logic [BYTE_W-1:0]  ev_bytes;

    always_comb begin
        st_d      = st_q;
        strobe_sh = evt_strobe >> st_q.sel;
        ev_hit    = 1'b0;
        ev_bytes  = '0;
        if (st_q.sel == CODE_AXID_RD) begin
            ev_hit   = rd_hit;
            ev_bytes = rd_bytes;
        end else if (st_q.sel == CODE_AXID_WR) begin
            ev_hit   = wr_hit;
            ev_bytes = wr_bytes;
        end else begin
            ev_hit   = strobe_sh[0];
        end

        if (!st_q.clr) st_d.clr = 1'b1;

        if (run && st_q.en && ev_hit) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.bcnt = st_q.bcnt + ev_bytes;
        end

        if (ctl_we) begin
            st_d.en  = ctl_en;
            st_d.sel = ctl_sel;
            st_d.clr = ctl_clr;
            if (!ctl_clr) begin
                st_d.cnt  = '0;
                st_d.bcnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.clr <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o   = st_q.sel;
    assign en_o    = st_q.en;
    assign clr_o   = st_q.clr;
    assign cnt_o   = st_q.cnt;
    assign bytes_o = st_q.bcnt;

    AST_CLR_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.clr && !ctl_we) |=> st_q.clr); // R4
    AST_SLICE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctl_we) |=> ($stable(st_q.cnt) && $stable(st_q.bcnt))); // R8
    AST_SLICE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> (EVC_W'(st_q.cnt - $past(st_q.cnt)) <= EVC_W'(1))); // R9
endmodule

// File: rtl/dram_perf_monitor.sv
module dram_perf_monitor
    import dpm_pkg::*;
#(
    parameter int CYC_W     = 32,
    parameter int EVC_W     = 32,
    parameter int NUM_EVT   = 128,
    parameter bit BYTE_READ = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         reg_addr,
    input  logic               reg_wen,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic               rd_req_vld,
    input  logic [15:0]        rd_req_id,
    input  logic [7:0]         rd_req_len,
    input  logic [2:0]         rd_req_size,
    input  logic               wr_req_vld,
    input  logic [15:0]        wr_req_id,
    input  logic [7:0]         wr_req_len,
    input  logic [2:0]         wr_req_size,
    output logic               irq
);
    typedef struct packed {
        logic              en0;
        logic              clr0;
        logic              ovf0;
        logic [CYC_W-1:0]  cnt0;
        logic [31:0]       filt;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [5:0]  word;
    logic        aligned;
    logic        ctl0_we;
    logic        run;
    logic        rd_hit, wr_hit;
    logic [BYTE_W-1:0] rd_bytes, wr_bytes;

    logic [7:0]        sl_sel   [1:NUM_CTR-1];
    logic              sl_en    [1:NUM_CTR-1];
    logic              sl_clr   [1:NUM_CTR-1];
    logic [EVC_W-1:0]  sl_cnt   [1:NUM_CTR-1];
    logic [BYTE_W-1:0] sl_bytes [1:NUM_CTR-1];

    assign word    = reg_addr[7:2];
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign ctl0_we = reg_wen && aligned && (word == 6'h00);
    assign run     = st_q.en0 && !st_q.ovf0;
    assign irq     = st_q.ovf0;

    dpm_axid_match u_rd_match (
        .req_vld (rd_req_vld), .req_id (rd_req_id), .req_len (rd_req_len),
        .req_size(rd_req_size), .filt_id (st_q.filt[15:0]),
        .filt_ign(st_q.filt[31:16]), .hit (rd_hit), .bytes (rd_bytes)
    );

    dpm_axid_match u_wr_match (
        .req_vld (wr_req_vld), .req_id (wr_req_id), .req_len (wr_req_len),
        .req_size(wr_req_size), .filt_id (st_q.filt[15:0]),
        .filt_ign(st_q.filt[31:16]), .hit (wr_hit), .bytes (wr_bytes)
    );

    for (genvar g = 1; g < NUM_CTR; g++) begin : g_slice
        logic sl_we;
        assign sl_we = reg_wen && aligned && (word == 6'(g));
        dpm_event_slice #(.EVC_W(EVC_W), .NUM_EVT(NUM_EVT)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .ctl_we    (sl_we),
            .ctl_sel   (reg_wdata[31:24]),
            .ctl_en    (reg_wdata[BIT_EN]),
            .ctl_clr   (reg_wdata[BIT_CLR]),
            .evt_strobe(evt_strobe),
            .rd_hit    (rd_hit),
            .rd_bytes  (rd_bytes),
            .wr_hit    (wr_hit),
            .wr_bytes  (wr_bytes),
            .sel_o     (sl_sel[g]),
            .en_o      (sl_en[g]),
            .clr_o     (sl_clr[g]),
            .cnt_o     (sl_cnt[g]),
            .bytes_o   (sl_bytes[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (run) st_d.cnt0 = st_q.cnt0 + 1'b1;
        if (ctl0_we) begin
            st_d.en0  = reg_wdata[BIT_EN];
            st_d.clr0 = reg_wdata[BIT_CLR];
            if (reg_wdata[BIT_CLR] && !st_q.clr0) st_d.cnt0 = '0;
            if (!reg_wdata[BIT_OVF]) st_d.ovf0 = 1'b0;
        end
        if (run && (st_q.cnt0 == '1)) st_d.ovf0 = 1'b1;
        if (reg_wen && aligned && (word == WORD_FILT)) st_d.filt = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.clr0 <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            if (word == 6'h00)
                reg_rdata = {29'b0, st_q.en0, st_q.clr0, st_q.ovf0};
            if (word == WORD_CNT_BASE)
                reg_rdata = 32'(st_q.cnt0);
            if (word == WORD_FILT)
                reg_rdata = st_q.filt;
            for (int n = 1; n < NUM_CTR; n++) begin
                if (word == 6'(n))
                    reg_rdata = {sl_sel[n], 21'b0, sl_en[n], sl_clr[n], 1'b0};
                if (word == WORD_CNT_BASE + 6'(n))
                    reg_rdata = 32'(sl_cnt[n]);
                if (BYTE_READ && (word == WORD_FILT + 6'(n)))
                    reg_rdata = sl_bytes[n];
            end
        end
    end

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctl0_we) |=> (st_q.cnt0 == CYC_W'($past(st_q.cnt0) + 1'b1))); // R2
    AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctl0_we) |=> $stable(st_q.cnt0)); // R10
    AST_OVF_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (st_q.cnt0 == '0)); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(ctl0_we && !reg_wdata[BIT_OVF])) |=> irq); // R11
endmodule

// File: tb/dram_perf_monitor_tb.sv
module dram_perf_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NEVT = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic            reg_wen = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NEVT-1:0] evt_strobe = '0;
    logic            rd_req_vld = 1'b0, wr_req_vld = 1'b0;
    logic [15:0]     rd_req_id = '0, wr_req_id = '0;
    logic [7:0]      rd_req_len = '0, wr_req_len = '0;
    logic [2:0]      rd_req_size = '0, wr_req_size = '0;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_perf_monitor #(.CYC_W(10), .EVC_W(8), .NUM_EVT(NEVT), .BYTE_READ(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe),
        .rd_req_vld(rd_req_vld), .rd_req_id(rd_req_id), .rd_req_len(rd_req_len),
        .rd_req_size(rd_req_size), .wr_req_vld(wr_req_vld), .wr_req_id(wr_req_id),
        .wr_req_len(wr_req_len), .wr_req_size(wr_req_size), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic rd_txn(input logic [15:0] id, input logic [7:0] len, input logic [2:0] sz);
        rd_req_vld = 1'b1; rd_req_id = id; rd_req_len = len; rd_req_size = sz;
        @(negedge clk);
        rd_req_vld = 1'b0;
    endtask

    task automatic wr_txn(input logic [15:0] id, input logic [7:0] len, input logic [2:0] sz);
        wr_req_vld = 1'b1; wr_req_id = id; wr_req_len = len; wr_req_size = sz;
        @(negedge clk);
        wr_req_vld = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctl0", 8'h00, 32'h2);
        rd_chk("R1 ctl1", 8'h04, 32'h2);
        rd_chk("R1 ctl3", 8'h0C, 32'h2);
        rd_chk("R1 cnt0", 8'h20, 32'h0);
        rd_chk("R1 cnt2", 8'h28, 32'h0);
        rd_chk("R1 filt", 8'h30, 32'h0);
        rd_chk("R1 bytes1", 8'h34, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_cycles;
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h6);
        rd_chk("R3 cnt0 cleared", 8'h20, 32'd0);
        repeat (20) @(negedge clk);
        rd_chk("R2 cnt0 after 20", 8'h20, 32'd20);
        wr(8'h00, 32'hFF00_0006);
        rd_chk("R2 sel ignored", 8'h00, 32'h6);
        rd_chk("R3 clr=1 no clear", 8'h20, 32'd21);
        wr(8'h00, 32'h0);
        rd_chk("R3 clr=0 keeps count", 8'h20, 32'd22);
        wr(8'h00, 32'h6);
        rd_chk("R3 second write clears", 8'h20, 32'd0);
    endtask

    task automatic t_select;
        logic [11:0] pat = 12'b1011_0101_1001;
        wr(8'h04, 32'h0); wr(8'h04, 32'h0500_0006);
        wr(8'h08, 32'h0); wr(8'h08, 32'h3F00_0006);
        wr(8'h0C, 32'h0); wr(8'h0C, 32'h5000_0006);
        for (int i = 0; i < 12; i++) begin
            evt_strobe = '1;
            evt_strobe[5]  = pat[i];
            evt_strobe[63] = (i < 3);
            @(negedge clk);
        end
        evt_strobe = '0;
        rd_chk("R5 code 0x05", 8'h24, 32'd7);
        rd_chk("R5 code 0x3F", 8'h28, 32'd3);
        rd_chk("R5 code beyond vector", 8'h2C, 32'd0);
    endtask

    task automatic t_slice_clear;
        wr(8'h04, 32'h0500_0004);
        rd_chk("R4 cnt1 zeroed", 8'h24, 32'd0);
        rd_chk("R4 clr reads 0", 8'h04, 32'h0500_0004);
        @(negedge clk);
        rd_chk("R4 clr restored", 8'h04, 32'h0500_0006);
    endtask

    task automatic t_filter;
        wr(8'h30, {16'h00FF, 16'h1200});
        rd_chk("R6 filt readback", 8'h30, 32'h00FF_1200);
        wr(8'h04, 32'h0); wr(8'h04, 32'h4100_0006);
        wr(8'h08, 32'h0); wr(8'h08, 32'h4200_0006);
        rd_txn(16'h1234, 8'd3, 3'd2);
        rd_txn(16'h1334, 8'd0, 3'd0);
        rd_txn(16'h12FF, 8'd0, 3'd3);
        wr_txn(16'h12AA, 8'd1, 3'd1);
        wr_txn(16'h3400, 8'd7, 3'd0);
        rd_chk("R6 read bursts", 8'h24, 32'd2);
        rd_chk("R6 write bursts", 8'h28, 32'd1);
        rd_chk("R7 read bytes", 8'h34, 32'd24);
        rd_chk("R7 write bytes", 8'h38, 32'd4);
        rd_chk("R7 unfiltered bytes", 8'h3C, 32'd0);
    endtask

    task automatic t_slice_wrap;
        wr(8'h00, 32'h0); wr(8'h00, 32'h6);
        wr(8'h04, 32'h0500_0004); wr(8'h04, 32'h0500_0006);
        evt_strobe[5] = 1'b1;
        repeat (260) @(negedge clk);
        evt_strobe = '0;
        rd_chk("R9 wrapped count", 8'h24, 32'd4);
        rd_chk("R9 ovf bit clear", 8'h04, 32'h0500_0006);
        chk("R9 no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_disable;
        logic [31:0] c0, c1;
        wr(8'h00, 32'h2);
        rd(8'h20, c0);
        rd(8'h24, c1);
        evt_strobe[5] = 1'b1;
        repeat (10) @(negedge clk);
        rd_chk("R10 cnt0 frozen", 8'h20, c0);
        rd_chk("R10 cnt1 frozen", 8'h24, c1);
        wr(8'h00, 32'h6);
        repeat (5) @(negedge clk);
        evt_strobe = '0;
        rd_chk("R10 cnt0 resumed", 8'h20, c0 + 32'd5);
        rd_chk("R10 cnt1 resumed", 8'h24, (c1 + 32'd5) & 32'hFF);
    endtask

    task automatic t_overflow;
        wr(8'h04, 32'h0500_0004); wr(8'h04, 32'h0500_0006);
        wr(8'h00, 32'h0); wr(8'h00, 32'h6);
        evt_strobe[5] = 1'b1;
        repeat (10) @(negedge clk);
        evt_strobe = '0;
        repeat (1013) @(negedge clk);
        rd_chk("R8 cnt0 at max", 8'h20, 32'd1023);
        chk("R8 irq low before wrap", {31'b0, irq}, 32'h0);
        @(negedge clk);
        rd_chk("R8 cnt0 wrapped", 8'h20, 32'd0);
        rd_chk("R8 ovf flag", 8'h00, 32'h7);
        chk("R8 irq high", {31'b0, irq}, 32'h1);
        evt_strobe[5] = 1'b1;
        repeat (10) @(negedge clk);
        evt_strobe = '0;
        rd_chk("R8 cnt1 frozen", 8'h24, 32'd10);
        rd_chk("R8 cnt0 frozen", 8'h20, 32'd0);
    endtask

    task automatic t_irq_clear;
        wr(8'h00, 32'h7);
        chk("R11 irq kept", {31'b0, irq}, 32'h1);
        @(negedge clk);
        rd_chk("R11 still frozen", 8'h20, 32'd0);
        wr(8'h00, 32'h6);
        chk("R11 irq cleared", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        rd_chk("R11 counting again", 8'h20, 32'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_cycles;
        t_select;
        t_slice_clear;
        t_filter;
        t_slice_wrap;
        t_disable;
        t_overflow;
        t_irq_clear;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule